// File: doc/BRIEF.md
# Multi-Channel Activity Loss Monitor

This block watches seventeen single-bit input lines. The lines are already synchronised to the system clock. Each line has its own idle timer. A line that makes no transition, rising or falling, for a programmable number of clock cycles is declared inactive. When a line becomes inactive, a sticky per-channel status bit is set. Any status bit that is also enabled in a mask register drives the single interrupt output high.

A host works through a small parallel register port with a 2-bit address, a write strobe and a read strobe. When the interrupt fires, the host reads the status word to find the failed channels. It can also read a separate live-inactivity word that shows which channels are idle right now. It then writes ones to the status bits it has handled. A channel that is still idle when its status bit is cleared does not set the bit again. The bit sets again only after the channel has shown activity and then gone quiet once more.

Top module: `act_loss_mon`

## Requirements
- R1: After reset, the status word and the live word read 0, the interrupt is low, the mask reads all ones (0x1FFFF) and the window reads the parameter DEF_WIN (64).
- R2: The idle window is held at address 3 as 16 bits (wdata[15:0]). On read, bits 31:16 return 0. The mask is held at address 2 as 17 bits, where bit i stands for channel i.
- R3: Once a channel has shown no edge for window clock cycles, its live bit (address 1, bit i) is 1, and its status bit (address 0, bit i) sets one cycle later.
- R4: Both a rising and a falling edge reload the channel's timer. A channel that toggles at intervals no longer than the window never raises its live or status bit.
- R5: A channel's live bit clears on the clock edge that samples a new input edge. Its status bit stays set.
- R6: A status bit clears only when the host writes 1 to that bit at address 0. Writing 0 leaves the bit unchanged.
- R7: A status bit sets only on a new transition into the inactive state. Clearing the bit while the channel stays idle keeps it clear.
- R8: The interrupt is high exactly when some channel has both its status bit and its mask bit set. Masked channels still record status.
- R9: A window value of 0 disables detection: the live bits stay 0 and no status bit sets.
- R10: Read data is registered. It appears the cycle after a read strobe and holds until the next strobe. Writes to address 1 have no effect.
- R11: Channels are independent. An idle channel is flagged while the other channels keep toggling, and the toggling channels are not flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ch_in | input | 17 | Synchronised channel inputs, bit i is channel i |
| bus_addr | input | 2 | Register address: 0 status, 1 live, 2 mask, 3 window |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, data valid the following cycle |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt, OR of status AND mask |

## Verification
On every cycle, the checker confirms four things. Status bits never drop without a write to the status address. Every new inactive transition lands in the status word on the next edge. An observed input edge clears that channel's live bit. A zero window keeps all live bits low. It also confirms that the interrupt stays quiet while no enabled status bit is set, and that read data holds between strobes. Some behaviours only the bench scenarios can show: the actual timeout length against the window, the boundary between a toggle period that is just short enough and one that is too long, the write-one-to-clear selectivity, the no-rearm rule for a channel that stays idle, and channel independence.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_LIVE   = 2'd1,
    REG_MASK   = 2'd2,
    REG_WINDOW = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/alm_rst_sync.sv
module alm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/alm_detector.sv
module alm_detector #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [WIN_W-1:0] win,
  output logic             live_o,
  output logic             loss_o
);
  logic             prev_q;
  logic [WIN_W-1:0] cnt_q, cnt_d;
  logic             idle_q;
  logic             edge_seen;
  logic             enabled;
  logic             idle_now;
  logic             cnt_en;

  always_comb begin
    edge_seen = din ^ prev_q;
    enabled   = (win != '0);
    idle_now  = enabled && (cnt_q >= win);
    cnt_en    = edge_seen || (enabled && (cnt_q < win));
    if (edge_seen) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      prev_q <= din;
      idle_q <= idle_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign live_o = idle_now;
  assign loss_o = idle_now & ~idle_q;
endmodule

// File: rtl/alm_regs.sv
module alm_regs
  import alm_pkg::*;
#(
  parameter int             NUM_CH  = 17,
  parameter int             WIN_W   = 16,
  parameter int             DATA_W  = 32,
  parameter logic [WIN_W-1:0] DEF_WIN = 16'd64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [NUM_CH-1:0] loss_evt,
  input  logic [NUM_CH-1:0] live,
  output logic [WIN_W-1:0]  win,
  output logic [NUM_CH-1:0] mask,
  output logic [NUM_CH-1:0] status,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int USED_W = (NUM_CH > WIN_W) ? NUM_CH : WIN_W;

  logic [WIN_W-1:0]  win_q, win_d;
  logic [NUM_CH-1:0] mask_q, mask_d;
  logic [NUM_CH-1:0] status_q, status_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [NUM_CH-1:0] clr_bits;
  logic              wr_win, wr_mask, wr_stat;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:USED_W];

  always_comb begin
    wr_win   = bus_we && (bus_addr == REG_WINDOW);
    wr_mask  = bus_we && (bus_addr == REG_MASK);
    wr_stat  = bus_we && (bus_addr == REG_STATUS);
    clr_bits = wr_stat ? bus_wdata[NUM_CH-1:0] : '0;
    win_d    = bus_wdata[WIN_W-1:0];
    mask_d   = bus_wdata[NUM_CH-1:0];
    status_d = (status_q & ~clr_bits) | loss_evt;
    unique case (bus_addr)
      REG_STATUS: rdata_d = {{(DATA_W-NUM_CH){1'b0}}, status_q};
      REG_LIVE:   rdata_d = {{(DATA_W-NUM_CH){1'b0}}, live};
      REG_MASK:   rdata_d = {{(DATA_W-NUM_CH){1'b0}}, mask_q};
      REG_WINDOW: rdata_d = {{(DATA_W-WIN_W){1'b0}}, win_q};
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= DEF_WIN;
    else if (wr_win) win_q <= win_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (wr_mask) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_re) rdata_q <= rdata_d;
  end

  assign win       = win_q;
  assign mask      = mask_q;
  assign status    = status_q;
  assign bus_rdata = rdata_q;
  assign irq_o     = |(status_q & mask_q);
endmodule

// File: rtl/act_loss_mon.sv
module act_loss_mon
  import alm_pkg::*;
#(
  parameter int               NUM_CH  = 17,
  parameter int               WIN_W   = 16,
  parameter int               DATA_W  = 32,
  parameter logic [WIN_W-1:0] DEF_WIN = 16'd64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic              rst_sync_n;
  logic [WIN_W-1:0]  win;
  logic [NUM_CH-1:0] mask;
  logic [NUM_CH-1:0] status;
  logic [NUM_CH-1:0] live;
  logic [NUM_CH-1:0] loss_evt;

  alm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    alm_detector #(.WIN_W(WIN_W)) u_det (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .din    (ch_in[g]),
      .win    (win),
      .live_o (live[g]),
      .loss_o (loss_evt[g])
    );
  end

  alm_regs #(
    .NUM_CH  (NUM_CH),
    .WIN_W   (WIN_W),
    .DATA_W  (DATA_W),
    .DEF_WIN (DEF_WIN)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .loss_evt  (loss_evt),
    .live      (live),
    .win       (win),
    .mask      (mask),
    .status    (status),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/alm_checker.sv
module alm_checker
  import alm_pkg::*;
#(
  parameter int NUM_CH = 17,
  parameter int WIN_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_in,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_o,
  input logic [WIN_W-1:0]  win,
  input logic [NUM_CH-1:0] mask,
  input logic [NUM_CH-1:0] status,
  input logic [NUM_CH-1:0] live
);
  logic [NUM_CH-1:0] live_d;
  logic [NUM_CH-1:0] ch_d;
  logic [1:0]        age;
  logic              ready;
  logic [NUM_CH-1:0] rise;
  logic [NUM_CH-1:0] toggled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_d <= '0;
      ch_d   <= '0;
      age    <= '0;
    end else begin
      live_d <= live;
      ch_d   <= ch_in;
      if (age != 2'd3) age <= age + 2'd1;
    end
  end

  assign ready   = (age == 2'd3);
  assign rise    = live & ~live_d;
  assign toggled = ch_in ^ ch_d;

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == REG_STATUS) |=> ((status & $past(status)) == $past(status)));

  assert_loss_recorded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && rise != '0) |=> ((status & $past(rise)) == $past(rise)));

  assert_edge_clears_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && toggled != '0) |=> ((live & $past(toggled)) == '0));

  assert_zero_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (win == '0) |-> (live == '0));

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & mask) == '0) |-> !irq_o);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));
endmodule

bind act_loss_mon alm_checker #(
  .NUM_CH (NUM_CH),
  .WIN_W  (WIN_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ch_in     (ch_in),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .win       (win),
  .mask      (mask),
  .status    (status),
  .live      (live)
);

// File: tb/tb_act_loss_mon.sv
module tb_act_loss_mon;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 17;
  localparam logic [31:0] ALL = 32'h0001FFFF;
  localparam int NVEC = 7;
  // {window[63:48], toggle period[47:32], run cycles[31:16], exp live[1], exp status[0]}
  localparam logic [63:0] VEC [NVEC] = '{
    {16'd20,  16'd5,  16'd100, 14'd0, 1'b0, 1'b0},
    {16'd10,  16'd9,  16'd100, 14'd0, 1'b0, 1'b0},
    {16'd8,   16'd0,  16'd40,  14'd0, 1'b1, 1'b1},
    {16'd3,   16'd0,  16'd10,  14'd0, 1'b1, 1'b1},
    {16'd100, 16'd0,  16'd60,  14'd0, 1'b0, 1'b0},
    {16'd100, 16'd0,  16'd150, 14'd0, 1'b1, 1'b1},
    {16'd0,   16'd0,  16'd100, 14'd0, 1'b0, 1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic [NCH-1:0] ch_in;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic        bus_re;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int          checks;
  int          errors;
  int          tog_per;
  logic [NCH-1:0] tog_mask;
  int          ph;
  logic [31:0] rd;

  act_loss_mon dut (
    .clk(clk), .rst_n(rst_n), .ch_in(ch_in), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (tog_per != 0) begin
      if (ph >= tog_per - 1) begin
        ch_in <= ch_in ^ tog_mask;
        ph    <= 0;
      end else begin
        ph <= ph + 1;
      end
    end else begin
      ph <= 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flush(input logic [31:0] w);
    wr(2'd3, w);
    tog_mask = '1; tog_per = 1;
    idle(3);
    wr(2'd0, ALL);
    idle(1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    tog_per = 0; tog_mask = '0;
    ch_in = '0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    rdreg(2'd0, rd); check("R1 status", rd, 32'd0);
    rdreg(2'd1, rd); check("R1 live", rd, 32'd0);
    rdreg(2'd2, rd); check("R1 mask", rd, ALL);
    rdreg(2'd3, rd); check("R1 window", rd, 32'd64);

    // R2 window width and readback
    wr(2'd3, 32'hFFFFABCD);
    rdreg(2'd3, rd); check("R2 window", rd, 32'h0000ABCD);
    wr(2'd2, 32'hFFFF0005);
    rdreg(2'd2, rd); check("R2 mask", rd, 32'h00010005);
    wr(2'd2, ALL);

    // Vector table: R3 R4 R9
    for (int v = 0; v < NVEC; v++) begin
      flush({16'd0, VEC[v][63:48]});
      tog_per = int'(VEC[v][47:32]);
      idle(int'(VEC[v][31:16]));
      rdreg(2'd1, rd);
      check(VEC[v][63:48] == 0 ? "R9 live" : "R3/R4 live", rd, VEC[v][1] ? ALL : 32'd0);
      rdreg(2'd0, rd);
      check(VEC[v][63:48] == 0 ? "R9 status" : "R3/R4 status", rd, VEC[v][0] ? ALL : 32'd0);
    end

    // R5 R6 R7: all idle, then reactivate channel 3
    flush(32'd10);
    tog_per = 0;
    idle(20);
    rdreg(2'd0, rd); check("R3 all flagged", rd, ALL);
    tog_mask = 17'h00008; tog_per = 1;
    idle(3);
    rdreg(2'd1, rd); check("R5 live ch3 cleared", rd, ALL & ~32'h8);
    rdreg(2'd0, rd); check("R5 status ch3 sticky", rd, ALL);
    wr(2'd0, 32'd0);
    rdreg(2'd0, rd); check("R6 write zero", rd, ALL);
    wr(2'd0, 32'h20);
    rdreg(2'd0, rd); check("R6 w1c ch5", rd, ALL & ~32'h20);
    idle(30);
    rdreg(2'd0, rd); check("R7 no rearm ch5", rd, ALL & ~32'h20);

    // R8 interrupt masking
    wr(2'd2, 32'd0);
    idle(1); check("R8 masked irq", {31'd0, irq_o}, 32'd0);
    rdreg(2'd0, rd); check("R8 status kept", rd, ALL & ~32'h20);
    wr(2'd2, 32'h20);
    idle(1); check("R8 mask on clear bit", {31'd0, irq_o}, 32'd0);
    wr(2'd2, 32'h80);
    idle(1); check("R8 mask on set bit", {31'd0, irq_o}, 32'd1);
    wr(2'd0, ALL);
    idle(1); check("R8 cleared irq", {31'd0, irq_o}, 32'd0);
    wr(2'd2, ALL);

    // R11 independence: channel 16 held
    flush(32'd10);
    tog_mask = 17'h0FFFF;
    idle(30);
    rdreg(2'd0, rd); check("R11 only ch16", rd, 32'h10000);
    rdreg(2'd1, rd); check("R11 live ch16", rd, 32'h10000);

    // R10 live read-only, rdata holds
    wr(2'd1, 32'd0);
    rdreg(2'd1, rd); check("R10 live write ignored", rd, 32'h10000);
    bus_addr = 2'd2;
    idle(5);
    check("R10 rdata hold", bus_rdata, 32'h10000);

    tog_per = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule